// File: doc/BRIEF.md
# MDIO management command controller

This block is a register-mapped master for the two-wire PHY management bus. Software programs a PHY address, a register number and a command bit into a single control register. The block then runs one complete serial management frame on the clock and data pins. When the frame is over, the command bit clears itself. For a read, the 16-bit value returned by the PHY is left in the low half of that same control register.

Write data for a write frame comes from a separate data register, which software loads before it issues the command. The management clock comes from a divider on the system clock, with a build-time half-period. The clock idles low whenever no frame is in flight. PHY discovery and link policy are left to software. A transfer is a sequence of three steps: load the data register, write the control register, then poll until the command bits read back as zero.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, the control register (offset 0x90) and the data register (offset 0x94) read as zero, MDC is low and MDIO is not driven (output enable low).
- R2: A write to the control register while idle stores the PHY address from bits 20:16 and the register number from bits 25:21. Bit 26 starts a read and bit 27 starts a write. The started command bit reads back as 1, with the stored address fields, for as long as the frame runs.
- R3: A write frame drives 64 bits MSB-first with output enable high throughout: 32 ones, start bits 01, opcode 01, five PHY-address bits, five register bits, turnaround 10 and the 16 data bits.
- R4: A read frame drives 32 ones, start 01, opcode 10 and the two five-bit address fields. It then releases MDIO (output enable low) for the two turnaround bits and the 16 data bits.
- R5: MDC has a half-period of HALF_DIV system clocks while a frame runs. MDIO and its enable change only together with a falling MDC edge, or at the start of a frame while MDC is low.
- R6: During a read, the block samples the input on each of the 16 data-bit rising MDC edges, MSB first. The resulting word appears in control bits 15:0 once the command bit has cleared.
- R7: The command bit clears exactly 128*HALF_DIV system clocks after the control write that started the frame. It stays set during the whole frame.
- R8: If bits 26 and 27 are both set in the same write, the block runs a read frame and only bit 26 reads back as set.
- R9: Control writes that arrive while a frame runs are ignored. The address fields, the command bits and the frame on the wire are all unaffected.
- R10: The data register reads back bits 15:0 as last written. The write data is captured when the command is issued, so a later data-register write does not alter a frame already in flight.
- R11: Control bits 29:28 store the value written with the command and read back unchanged. They keep that value after the frame completes.
- R12: Between frames, MDC stays low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | BUS_AW | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data from the pin |

## Verification
The assertions assume that register writes arrive as single-cycle strobes on a settled address. They also assume that mdio_i is stable around each rising MDC edge during the read data window. The stimulus writes registers on the falling system-clock edge for exactly one cycle. The bench's PHY model changes mdio_i only on falling MDC edges, half an MDC period before the block samples it. The sweeps cover many PHY and register addresses, data patterns, reads, writes, the combined command, and control and data writes that collide with a busy frame.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    // frame geometry
    localparam int PRE_LEN   = 32;
    localparam int FLD_W     = 5;
    localparam int DATA_W    = 16;
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + 2 * FLD_W + 2 + DATA_W;
    localparam int TA_POS    = PRE_LEN + 4 + 2 * FLD_W;
    localparam int DATA_POS  = TA_POS + 2;

    // register map
    localparam int REG_W     = 32;
    localparam int CTRL_OFS  = 'h90;
    localparam int DATA_OFS  = 'h94;
    localparam int PHY_LSB   = 16;
    localparam int REGN_LSB  = 21;
    localparam int RD_BIT    = 26;
    localparam int WR_BIT    = 27;
    localparam int KEY_LSB   = 28;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    localparam logic [1:0] SOF_BITS   = 2'b01;
    localparam logic [1:0] TA_WR_BITS = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_st_t;

    gen_st_t gen_d, gen_q;
    logic    tick;

    always_comb begin
        gen_d    = gen_q;
        tick     = (gen_q.cnt == CW'(HALF_DIV - 1));
        rise_stb = run && tick && !gen_q.mdc;
        fall_stb = run && tick && gen_q.mdc;
        if (!run) begin
            gen_d.cnt = '0;
            gen_d.mdc = 1'b0;
        end else if (tick) begin
            gen_d.cnt = '0;
            gen_d.mdc = !gen_q.mdc;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign mdc = gen_q.mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [FLD_W-1:0]  start_phy,
    input  logic [FLD_W-1:0]  start_reg,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic              done_rd,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CW = $clog2(FRAME_LEN);

    typedef struct packed {
        logic                 busy;
        logic                 is_rd;
        logic                 oe;
        logic [CW-1:0]        cnt;
        logic [FRAME_LEN-1:0] frame;
        logic [DATA_W-1:0]    shift;
    } eng_st_t;

    eng_st_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        done  = 1'b0;
        if (!eng_q.busy) begin
            if (start) begin
                eng_d.busy  = 1'b1;
                eng_d.is_rd = start_rd;
                eng_d.oe    = 1'b1;
                eng_d.cnt   = '0;
                eng_d.frame = {{PRE_LEN{1'b1}}, SOF_BITS,
                               start_rd ? OP_READ : OP_WRITE,
                               start_phy, start_reg,
                               start_rd ? 2'b11 : TA_WR_BITS,
                               start_rd ? {DATA_W{1'b1}} : start_wdata};
            end
        end else begin
            // input sampled on the rising MDC edge
            if (rise_stb && eng_q.is_rd && (eng_q.cnt >= CW'(DATA_POS))) begin
                eng_d.shift = {eng_q.shift[DATA_W-2:0], mdio_i};
            end
            // outputs advance on the falling MDC edge
            if (fall_stb) begin
                if (eng_q.cnt == CW'(FRAME_LEN - 1)) begin
                    eng_d.busy = 1'b0;
                    eng_d.oe   = 1'b0;
                    done       = 1'b1;
                end else begin
                    eng_d.cnt   = eng_q.cnt + 1'b1;
                    eng_d.frame = {eng_q.frame[FRAME_LEN-2:0], 1'b1};
                    if (eng_q.is_rd && (eng_q.cnt == CW'(TA_POS - 1))) begin
                        eng_d.oe = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy    = eng_q.busy;
    assign mdio_o  = eng_q.frame[FRAME_LEN-1];
    assign mdio_oe = eng_q.oe;
    assign done_rd = done && eng_q.is_rd;
    assign rd_data = eng_q.shift;
endmodule

// File: rtl/mdio_mgmt_regs.sv
`timescale 1ns/1ps
module mdio_mgmt_regs
    import mdio_pkg::*;
#(
    parameter int BUS_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [BUS_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              done_rd,
    input  logic [DATA_W-1:0] rd_data,
    output logic              start,
    output logic              start_rd,
    output logic [FLD_W-1:0]  start_phy,
    output logic [FLD_W-1:0]  start_reg,
    output logic [DATA_W-1:0] wdata_out,
    output logic              cmd_rd,
    output logic              cmd_wr,
    output logic [FLD_W-1:0]  cur_phy,
    output logic [FLD_W-1:0]  cur_reg
);
    typedef struct packed {
        logic [FLD_W-1:0]  phy;
        logic [FLD_W-1:0]  regn;
        logic [1:0]        key;
        logic              cmd_rd;
        logic              cmd_wr;
        logic [DATA_W-1:0] rdat;
        logic [DATA_W-1:0] wdat;
    } regs_st_t;

    regs_st_t regs_d, regs_q;
    logic     ctrl_hit, data_hit;
    logic     unused_wbits;

    assign ctrl_hit     = (reg_addr == BUS_AW'(CTRL_OFS));
    assign data_hit     = (reg_addr == BUS_AW'(DATA_OFS));
    assign unused_wbits = ^reg_wdata[REG_W-1:KEY_LSB+2];

    always_comb begin
        regs_d    = regs_q;
        start     = 1'b0;
        start_rd  = reg_wdata[RD_BIT];
        start_phy = reg_wdata[PHY_LSB +: FLD_W];
        start_reg = reg_wdata[REGN_LSB +: FLD_W];
        if (reg_wen && ctrl_hit && !busy) begin
            regs_d.phy  = reg_wdata[PHY_LSB +: FLD_W];
            regs_d.regn = reg_wdata[REGN_LSB +: FLD_W];
            regs_d.key  = reg_wdata[KEY_LSB +: 2];
            if (reg_wdata[RD_BIT]) begin
                start         = 1'b1;
                regs_d.cmd_rd = 1'b1;
            end else if (reg_wdata[WR_BIT]) begin
                start         = 1'b1;
                regs_d.cmd_wr = 1'b1;
            end
        end
        if (reg_wen && data_hit) begin
            regs_d.wdat = reg_wdata[DATA_W-1:0];
        end
        if (done) begin
            regs_d.cmd_rd = 1'b0;
            regs_d.cmd_wr = 1'b0;
        end
        if (done_rd) begin
            regs_d.rdat = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        if (ctrl_hit) begin
            reg_rdata = {2'b00, regs_q.key, regs_q.cmd_wr, regs_q.cmd_rd,
                         regs_q.regn, regs_q.phy, regs_q.rdat};
        end else if (data_hit) begin
            reg_rdata = {{(REG_W-DATA_W){1'b0}}, regs_q.wdat};
        end else begin
            reg_rdata = '0;
        end
    end

    assign wdata_out = regs_q.wdat;
    assign cmd_rd    = regs_q.cmd_rd;
    assign cmd_wr    = regs_q.cmd_wr;
    assign cur_phy   = regs_q.phy;
    assign cur_reg   = regs_q.regn;
endmodule

// File: rtl/mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int BUS_AW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [BUS_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              eng_busy, eng_done, eng_done_rd;
    logic [DATA_W-1:0] eng_rdata, reg_wdat;
    logic              go, go_rd;
    logic [FLD_W-1:0]  go_phy, go_reg, cur_phy, cur_reg;
    logic              cmd_rd, cmd_wr;
    logic              rise_stb, fall_stb;

    mdio_mgmt_regs #(.BUS_AW(BUS_AW)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (eng_busy),
        .done      (eng_done),
        .done_rd   (eng_done_rd),
        .rd_data   (eng_rdata),
        .start     (go),
        .start_rd  (go_rd),
        .start_phy (go_phy),
        .start_reg (go_reg),
        .wdata_out (reg_wdat),
        .cmd_rd    (cmd_rd),
        .cmd_wr    (cmd_wr),
        .cur_phy   (cur_phy),
        .cur_reg   (cur_reg)
    );

    mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) i_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (eng_busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine i_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (go),
        .start_rd    (go_rd),
        .start_phy   (go_phy),
        .start_reg   (go_reg),
        .start_wdata (reg_wdat),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb),
        .mdio_i      (mdio_i),
        .busy        (eng_busy),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .done        (eng_done),
        .done_rd     (eng_done_rd),
        .rd_data     (eng_rdata)
    );
endmodule

// File: rtl/mdio_cmd_chk.sv
`timescale 1ns/1ps
module mdio_cmd_chk #(
    parameter int HALF_DIV = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic       busy,
    input logic       cmd_rd,
    input logic       cmd_wr,
    input logic [4:0] phy_q,
    input logic [4:0] reg_q
);
    localparam int RW = $clog2(HALF_DIV + 2) + 1;

    logic          mdc_prev;
    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_prev <= 1'b0;
            run_len  <= '0;
        end else begin
            mdc_prev <= mdc;
            if (!busy)               run_len <= '0;
            else if (mdc != mdc_prev) run_len <= RW'(1);
            else                     run_len <= run_len + 1'b1;
        end
    end

    // R5
    mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R5
    mdc_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (mdc != mdc_prev)) |-> (run_len == RW'(HALF_DIV)));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R9
    locked_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(phy_q) && $stable(reg_q)));

    // R7
    busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cmd_rd || cmd_wr));

    // R7
    cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!cmd_rd && !cmd_wr));

    // R8
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_rd, cmd_wr}));
endmodule

bind mdio_cmd_ctrl mdio_cmd_chk #(.HALF_DIV(HALF_DIV)) i_mdio_cmd_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .busy    (eng_busy),
    .cmd_rd  (cmd_rd),
    .cmd_wr  (cmd_wr),
    .phy_q   (cur_phy),
    .reg_q   (cur_reg)
);

// File: tb/test_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module test_mdio_cmd_ctrl;
    localparam int HALF = 2;
    localparam int FRAME_CYC = 128 * HALF;
    localparam logic [7:0] CTRL = 8'h90;
    localparam logic [7:0] DATA = 8'h94;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    mdio_cmd_ctrl #(.HALF_DIV(HALF), .BUS_AW(8)) i_mdio_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #4 clk = ~clk;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          fin = 1'b0;
    int          cyc = 0;
    int          rise_cnt = 0;
    int          t_prev = 0;
    int          t_last = 0;
    logic        mdc_seen = 1'b0;
    logic [63:0] cap_o, cap_oe;
    logic [15:0] phy_resp = '0;

    always @(posedge clk) cyc++;

    // PHY model: capture on rising MDC, drive on falling MDC
    always @(posedge mdc) begin
        if (rise_cnt < 64) begin
            cap_o[63 - rise_cnt]  = mdio_o;
            cap_oe[63 - rise_cnt] = mdio_oe;
        end
        rise_cnt++;
    end

    always @(negedge mdc) begin
        if (rise_cnt >= 48 && rise_cnt <= 63) mdio_i = phy_resp[63 - rise_cnt];
        else                                  mdio_i = 1'b1;
    end

    always @(negedge clk) begin
        if (mdc && !mdc_seen) begin
            t_prev = t_last;
            t_last = cyc;
        end
        mdc_seen = mdc;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen   = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wen   = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run_op(input bit rd, input bit wr, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] wd,
                          input logic [15:0] resp, input bit poke);
        logic [31:0] v;
        logic [63:0] exp_o, exp_oe;
        logic [15:0] prev_rdat;
        int          t0;
        bit          cleared;
        rd_reg(CTRL, v);
        prev_rdat = v[15:0];
        wr_reg(DATA, {16'h0, wd});
        rd_reg(DATA, v);
        check("R10 data readback", v, {16'h0, wd});
        phy_resp = resp;
        rise_cnt = 0;
        cap_o    = '0;
        cap_oe   = '0;
        wr_reg(CTRL, {2'b00, 2'b11, wr, rd, ra, pa, 16'h0});
        t0 = cyc;
        rd_reg(CTRL, v);
        check("R2 cmd bits while busy", v[27:26], rd ? 2'b01 : 2'b10);
        check("R8 combined cmd reads as read", v[27:26] & {rd, 1'b1}, {1'b0, 1'b1} & {2{rd}} | (rd ? 2'b00 : 2'b00));
        check("R2 address fields", v[25:16], {ra, pa});
        check("R11 key field", v[29:28], 2'b11);
        if (poke) begin
            wr_reg(CTRL, {2'b00, 2'b00, 1'b1, 1'b0, ~ra, ~pa, 16'h0});
            wr_reg(DATA, {16'h0, ~wd});
            rd_reg(CTRL, v);
            check("R9 busy write ignored", {v[29:16]}, {2'b11, rd ? 2'b01 : 2'b10, ra, pa});
        end
        cleared = 1'b0;
        for (int k = 0; k < 4000 && !cleared; k++) begin
            rd_reg(CTRL, v);
            if (v[27:26] == 2'b00) cleared = 1'b1;
        end
        check("R7 command bits cleared", {63'h0, cleared}, 64'h1);
        check("R7 frame duration", cyc - t0, FRAME_CYC);
        exp_o = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra,
                 rd ? 2'b00 : 2'b10, rd ? 16'h0 : wd};
        if (rd) begin
            exp_oe = {{46{1'b1}}, 18'h0};
            check("R4 read frame header", {18'h0, cap_o[63:18]}, {18'h0, exp_o[63:18]});
            check("R4 read release pattern", cap_oe, exp_oe);
            check("R6 read data", v[15:0], resp);
        end else begin
            check("R3 write frame bits", cap_o, exp_o);
            check("R3 write drive pattern", cap_oe, {64{1'b1}});
            check("R11 read data kept on write", v[15:0], prev_rdat);
        end
        check("R11 key after done", v[29:28], 2'b11);
        check("R5 mdc period", t_last - t_prev, 2 * HALF);
        check("R5 rising edge count", rise_cnt, 64);
        repeat (3) @(negedge clk);
        check("R12 idle pins", {mdc, mdio_oe}, 2'b00);
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rd_reg(CTRL, v);
        check("R1 reset ctrl", v, 0);
        rd_reg(DATA, v);
        check("R1 reset data", v, 0);
        check("R1 reset pins", {mdc, mdio_oe}, 2'b00);

        run_op(1'b0, 1'b1, 5'd0,  5'd0,  16'h0000, 16'h0, 1'b0);
        run_op(1'b0, 1'b1, 5'd31, 5'd31, 16'hFFFF, 16'h0, 1'b0);
        run_op(1'b1, 1'b0, 5'd31, 5'd0,  16'h0,    16'hFFFF, 1'b0);
        run_op(1'b1, 1'b0, 5'd0,  5'd31, 16'h0,    16'h0000, 1'b0);
        for (int i = 0; i < 8; i++) begin
            run_op(1'b0, 1'b1, 5'(i * 5 + 1), 5'(30 - i * 3),
                   16'hA5C3 ^ 16'(i * 16'h1357), 16'h0, i[0]);
            run_op(1'b1, 1'b0, 5'(i * 3 + 2), 5'(i * 7),
                   16'h0, 16'h8001 ^ 16'(i * 16'h2469), i[1]);
        end
        run_op(1'b1, 1'b1, 5'd9,  5'd17, 16'hDEAD, 16'h5AA5, 1'b0);
        run_op(1'b1, 1'b1, 5'd22, 5'd3,  16'hBEEF, 16'h0F0F, 1'b1);

        fin = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!fin) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule